// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache that sits between a processor load/store port and a word-addressed main memory. It holds 1K words, arranged as 256 lines of four 32-bit words, with one placement per address. The processor presents a 32-bit byte address for word loads and stores. Main memory is reached one word per beat: each beat is a request that the memory accepts by raising a ready signal.

Stores are kept in the cache. A line is written back to memory only when it is evicted and its dirty flag is set. A store that misses first brings the whole block in, and then merges the store into it. The processor holds its request for as long as the stall output is high. After a miss the controller installs the line and then replays the held request as a hit. A stalled access therefore always completes as a one-cycle hit, with its result registered.

Top module: `dmc_cache`

## Requirements
- R1: The byte address splits into tag = bits 31..12, line index = bits 11..4 and word-in-line = bits 3..2. Bits 1..0 are ignored: any byte offset selects the same word.
- R2: A lookup hits only when the line's valid flag is 1 and its stored tag equals the address tag. A line whose valid flag is 0 misses even when its tag matches, for example tag 0 right after reset.
- R3: A load hit completes with no memory beat. `cpu_done` and `cpu_rdata` come up in the cycle after the edge that accepts the request, and `cpu_stall` stays 0 for that request.
- R4: A store hit writes only the cache and marks the line dirty. The memory word keeps its old value until the line is evicted.
- R5: A store miss first refills the block from memory and then merges the store word into it. The line is left dirty, so its next eviction writes it back.
- R6: A miss on a line that is invalid or clean performs exactly 4 read beats and no write. The memory word address is {tag, index, word}, and the beats run over word offsets 0, 1, 2, 3 in that order.
- R7: A miss on a dirty line first writes the old line back in 4 beats, at {old tag, index, offsets 0..3}, carrying the latest stored data. It then does the 4 read beats.
- R8: Each processor access costs 0, 4 or 8 memory beats (hit, clean miss, dirty miss). A refilled line is installed clean.
- R9: `cpu_stall` is high during every miss, write-back, refill and install cycle. The result of a missing access appears only after the whole fill has completed.
- R10: Reset clears every valid flag and every dirty flag. After reset no request is stalled unless it is made, and no memory request is raised.
- R11: A memory request keeps its direction, its address and its write data unchanged until the memory raises `mem_ready`. The read and write requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| cpu_req | input | 1 | Processor access request, held while `cpu_stall` is high |
| cpu_we | input | 1 | 1 = store word, 0 = load word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Request not accepted in this cycle; hold it |
| cpu_done | output | 1 | One-cycle pulse: the access accepted at the previous edge is finished |
| cpu_rdata | output | 32 | Load result, valid with `cpu_done` for loads |
| mem_rd_req | output | 1 | Read beat request |
| mem_wr_req | output | 1 | Write beat request |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, sampled when `mem_ready` is 1 |
| mem_ready | input | 1 | Memory accepts the current beat at this edge |

## Verification
The driver first runs fixed sequences. A first touch tells a cold miss apart from a hit. Word neighbours in the same line tell spatial reuse apart from refetch. Different byte offsets confirm that the low bits are ignored. A store hit followed by an eviction shows the old memory value first and the new one after. A store miss followed by a conflicting load must show both the merge and the later write-back. A long pseudo-random stream then mixes four tags over eight lines under a memory that accepts beats irregularly. The beat count expected for each access comes from an independent model of the tags and the valid and dirty flags. Every write beat is compared with the latest stored value, and every beat's word offset is checked.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2,
    ST_UPDATE = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             install_en,
  input  logic [IDX_W-1:0] install_idx,
  input  logic [TAG_W-1:0] install_tag,
  input  logic             dirty_set_en,
  input  logic [IDX_W-1:0] dirty_set_idx,
  output logic             hit,
  output logic             victim_dirty,
  output logic [TAG_W-1:0] victim_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (install_en) begin
      valid_d[install_idx] = 1'b1;
      dirty_d[install_idx] = 1'b0;
    end
    if (dirty_set_en) dirty_d[dirty_set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (install_en) tag_q[install_idx] <= install_tag;
  end

  assign hit          = valid_q[rd_idx] && (tag_q[rd_idx] == cmp_tag);
  assign victim_dirty = valid_q[rd_idx] && dirty_q[rd_idx];
  assign victim_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WORD_W-1:0] w_word,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [WORD_W-1:0] r_word,
  output logic [DATA_W-1:0] r_data
);
  localparam int DEPTH = 1 << (IDX_W + WORD_W);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[{w_idx, w_word}] <= w_data;
  end

  assign r_data = mem_q[{r_idx, r_word}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 2,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  localparam int MADDR_W = TAG_W + IDX_W + WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [TAG_W-1:0]   cpu_tag,
  input  logic [IDX_W-1:0]   cpu_idx,
  input  logic [WORD_W-1:0]  cpu_word,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_stall,
  output logic               cpu_done,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic               hit,
  input  logic               victim_dirty,
  input  logic [TAG_W-1:0]   victim_tag,
  output logic [IDX_W-1:0]   look_idx,
  output logic               install_en,
  output logic [TAG_W-1:0]   install_tag,
  output logic               dirty_set_en,
  output logic               data_we,
  output logic [IDX_W-1:0]   data_w_idx,
  output logic [WORD_W-1:0]  data_w_word,
  output logic [DATA_W-1:0]  data_w_data,
  output logic [WORD_W-1:0]  data_r_word,
  input  logic [DATA_W-1:0]  data_r_data,
  output logic               mem_rd_req,
  output logic               mem_wr_req,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ready
);
  dmc_state_e        state_q, state_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0]  lat_idx_q;
  logic [TAG_W-1:0]  lat_tag_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              idle, accept, miss_start, last_beat;

  assign idle       = (state_q == ST_IDLE);
  assign accept     = idle && cpu_req && hit;
  assign miss_start = idle && cpu_req && !hit;
  assign last_beat  = (beat_q == {WORD_W{1'b1}});

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (miss_start) begin
        beat_d  = '0;
        state_d = victim_dirty ? ST_WBACK : ST_REFILL;
      end
      ST_WBACK: if (mem_ready) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_REFILL;
      end
      ST_REFILL: if (mem_ready) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_UPDATE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      done_q  <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_start) begin
      lat_idx_q <= cpu_idx;
      lat_tag_q <= cpu_tag;
    end
    if (accept && !cpu_we) rdata_q <= data_r_data;
  end

  assign look_idx     = idle ? cpu_idx : lat_idx_q;
  assign data_r_word  = idle ? cpu_word : beat_q;
  assign install_en   = (state_q == ST_UPDATE);
  assign install_tag  = lat_tag_q;
  assign dirty_set_en = accept && cpu_we;

  assign data_we      = (accept && cpu_we) || ((state_q == ST_REFILL) && mem_ready);
  assign data_w_idx   = idle ? cpu_idx : lat_idx_q;
  assign data_w_word  = idle ? cpu_word : beat_q;
  assign data_w_data  = idle ? cpu_wdata : mem_rdata;

  assign mem_wr_req   = (state_q == ST_WBACK);
  assign mem_rd_req   = (state_q == ST_REFILL);
  assign mem_addr     = {(mem_wr_req ? victim_tag : lat_tag_q), lat_idx_q, beat_q};
  assign mem_wdata    = data_r_data;

  assign cpu_stall    = !idle || miss_start;
  assign cpu_done     = done_q;
  assign cpu_rdata    = rdata_q;
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 2,
  localparam int BYTE_W  = $clog2(DATA_W / 8),
  localparam int TAG_W   = ADDR_W - IDX_W - WORD_W - BYTE_W,
  localparam int MADDR_W = ADDR_W - BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_stall,
  output logic               cpu_done,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               mem_rd_req,
  output logic               mem_wr_req,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ready
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic [WORD_W-1:0] cpu_word;
  logic [BYTE_W-1:0] byte_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // R1: address field split, byte offset dropped
  assign cpu_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx     = cpu_addr[BYTE_W+WORD_W +: IDX_W];
  assign cpu_word    = cpu_addr[BYTE_W +: WORD_W];
  assign byte_unused = cpu_addr[BYTE_W-1:0];

  logic              hit, victim_dirty, install_en, dirty_set_en, data_we;
  logic [TAG_W-1:0]  victim_tag, install_tag;
  logic [IDX_W-1:0]  look_idx, data_w_idx;
  logic [WORD_W-1:0] data_w_word, data_r_word;
  logic [DATA_W-1:0] data_w_data, data_r_data;

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(look_idx), .cmp_tag(cpu_tag),
    .install_en(install_en), .install_idx(look_idx), .install_tag(install_tag),
    .dirty_set_en(dirty_set_en), .dirty_set_idx(cpu_idx),
    .hit(hit), .victim_dirty(victim_dirty), .victim_tag(victim_tag)
  );

  dmc_data_store #(.IDX_W(IDX_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(data_we), .w_idx(data_w_idx), .w_word(data_w_word),
    .w_data(data_w_data), .r_idx(look_idx), .r_word(data_r_word), .r_data(data_r_data)
  );

  dmc_ctrl #(.IDX_W(IDX_W), .WORD_W(WORD_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
    .cpu_word(cpu_word), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .hit(hit), .victim_dirty(victim_dirty), .victim_tag(victim_tag),
    .look_idx(look_idx), .install_en(install_en), .install_tag(install_tag),
    .dirty_set_en(dirty_set_en), .data_we(data_we), .data_w_idx(data_w_idx),
    .data_w_word(data_w_word), .data_w_data(data_w_data),
    .data_r_word(data_r_word), .data_r_data(data_r_data),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int MADDR_W = 30,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               cpu_stall,
  input logic               cpu_done,
  input logic               mem_rd_req,
  input logic               mem_wr_req,
  input logic               mem_ready,
  input logic [MADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0]  mem_wdata
);
  logic [3:0] beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     beats_q <= '0;
    else if (cpu_done)                              beats_q <= '0;
    else if ((mem_rd_req || mem_wr_req) && mem_ready) beats_q <= beats_q + 4'd1;
  end

  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> (!mem_rd_req && !mem_wr_req));

  p_accept_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |=> cpu_done);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(cpu_req && !cpu_stall));

  p_mem_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> cpu_stall);

  p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_ready) |=> (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata)));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_ready) |=> (mem_rd_req && $stable(mem_addr)));

  p_xfer_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> (beats_q == 4'd0 || beats_q == 4'd4 || beats_q == 4'd8));

  p_xfer_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beats_q <= 4'd8);
endmodule

bind dmc_cache dmc_checker #(.MADDR_W(MADDR_W), .DATA_W(DATA_W)) u_dmc_checker (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
  .cpu_done(cpu_done), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_dmc_cache.sv
`timescale 1ns/1ps
module test_dmc_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata;
  logic        cpu_stall, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req, mem_wr_req, mem_ready;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  dmc_cache i_dmc_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int checks = 0;
  int fails  = 0;
  int beat_cnt = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_load;
    logic [31:0] data;
    int          beats;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  logic [31:0] arch [int];
  logic [31:0] phys [int];
  bit          mval   [256];
  logic [19:0] mtag   [256];
  bit          mdirty [256];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] seed_word(int a);
    logic [31:0] aa;
    aa = a;
    return (aa * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction
  function automatic logic [31:0] arch_get(int a);
    return arch.exists(a) ? arch[a] : seed_word(a);
  endfunction
  function automatic logic [31:0] phys_get(int a);
    return phys.exists(a) ? phys[a] : seed_word(a);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Memory responder: beats granted irregularly, order and data checked (R6, R7, R11)
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = 1'b0;
    if ((mem_rd_req || mem_wr_req) && (lfsr[0] || lfsr[1])) begin
      mem_ready = 1'b1;
      chk(mem_addr[1:0] == beat_cnt[1:0], "R6/R7 beat offset order",
          {30'd0, mem_addr[1:0]}, beat_cnt);
      if (mem_wr_req) begin
        chk(beat_cnt < 4, "R7 write-back precedes refill", beat_cnt, 0);
        chk(mem_wdata === arch_get(int'(mem_addr)), "R7 write-back data",
            mem_wdata, arch_get(int'(mem_addr)));
        phys[int'(mem_addr)] = mem_wdata;
      end else begin
        mem_rdata = phys_get(int'(mem_addr));
      end
      beat_cnt++;
    end
  end

  // Monitor: pops scoreboard on each completion (R3, R5, R8, R9)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cpu_done === 1'b1) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(beat_cnt == e.beats, {e.req, " R8 beat count"}, beat_cnt, e.beats);
        if (e.is_load)
          chk(cpu_rdata === e.data, {e.req, " load data"}, cpu_rdata, e.data);
      end
      beat_cnt = 0;
    end
  end

  // Driver: model prediction pushed, request held until accepted
  task automatic access(bit we, logic [31:0] addr, logic [31:0] wd, string req);
    int   wa, idx;
    logic [19:0] tg;
    bit   hit;
    exp_t e;
    wa  = int'(addr[31:2]);
    idx = int'(addr[11:4]);
    tg  = addr[31:12];
    hit = mval[idx] && (mtag[idx] == tg);
    e.beats = hit ? 0 : (mdirty[idx] ? 8 : 4);
    if (!hit) begin mval[idx] = 1'b1; mtag[idx] = tg; mdirty[idx] = 1'b0; end
    if (we) begin mdirty[idx] = 1'b1; arch[wa] = wd; end
    e.is_load = !we;
    e.data    = arch_get(wa);
    e.req     = req;
    sb_q.push_back(e);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    chk(cpu_stall == !hit, hit ? "R3 hit not stalled" : "R9 miss stalled",
        {31'd0, cpu_stall}, {31'd0, !hit});
    while (cpu_stall) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mval[i] = 0; mdirty[i] = 0; mtag[i] = '0; end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_ready = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: idle after reset
    chk(!cpu_stall && !cpu_done, "R10 reset stall/done", {cpu_stall, cpu_done}, 0);
    chk(!mem_rd_req && !mem_wr_req, "R10 reset mem requests", {mem_rd_req, mem_wr_req}, 0);

    // R2/R10: tag 0 after reset still misses; R6 clean fill
    access(0, 32'h0000_0000, 0, "R2 cold miss tag0");
    access(0, 32'h0000_0004, 0, "R3 load hit neighbour");
    access(0, 32'h0000_000B, 0, "R1 byte offset ignored");
    access(1, 32'h0000_0005, 32'h1111_2222, "R4 store hit");
    chk(phys_get(1) === seed_word(1), "R4 memory stale after store hit", phys_get(1), seed_word(1));
    access(0, 32'h0000_0004, 0, "R4 load after store hit");
    access(0, 32'h0000_1000, 0, "R7 dirty eviction");
    chk(phys_get(1) === 32'h1111_2222, "R7 memory updated by eviction", phys_get(1), 32'h1111_2222);
    access(0, 32'h0000_0004, 0, "R8 clean refetch");
    // R5: store miss merges into filled block
    access(1, 32'h0000_2013, 32'hCAFE_0001, "R5 store miss");
    access(0, 32'h0000_2010, 0, "R5 merged word");
    access(0, 32'h0000_2014, 0, "R5 filled neighbour");
    access(0, 32'h0000_3010, 0, "R5 store-miss line dirty");
    access(0, 32'h0000_0050, 0, "R2 invalid line tag0");

    // pseudo-random mix (R1..R9)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {18'd0, lfsr[1:0], 5'd0, lfsr[4:2], lfsr[6:5], lfsr[8:7]};
      access(lfsr[9], a, {lfsr, lfsr ^ 16'h5A5A}, "R8 random mix");
    end
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R9 all accesses completed", sb_q.size(), 0);
    finish_run();
  end
endmodule